// File: doc/BRIEF.md
# System-Management Base Relocation Unit

This unit keeps the base address of the system-management memory region for a processor core and derives every address that hangs off it. When the core enters system-management mode, the unit publishes the handler start address, the top of the state-save area (where saving begins) and the address of the save-area word that records the base. It also supplies the current base as the data for that word, so the save sequence can write it out.

When the core executes a resume from system-management mode, the save sequence returns the 32-bit word read back from that save-area location. The unit checks the word. A value on a 32 KB boundary becomes the base for the next entry, and the addresses already published for the current entry stay as they are. A value with any of its low fifteen bits set puts the core into a sticky shutdown state and leaves the base untouched. Entry and resume are single-cycle request pulses. The unit also drives a constant revision word whose bit 17 advertises that relocation is supported.

Top module: `smm_reloc_unit`

## Requirements
- R1: While `rst_n` is low, and after it rises, `base_out` holds 0x0003_0000, `in_smm`, `shutdown` and `smi_entered` are 0, and `handler_addr`, `save_top_addr`, `base_slot_addr` and `base_slot_data` are 0.
- R2: An entry pulse that is accepted (`in_smm` and `shutdown` both 0) gives a one-cycle `smi_entered` pulse one cycle later, with `handler_addr` = base + 0x8000. The address sum is taken modulo 2^32.
- R3: With that same pulse, `save_top_addr` = base + 0xFFFF, which is the highest address of the save area and the point where saving starts.
- R4: With that same pulse, `base_slot_addr` = base + 0xFEF8 and `base_slot_data` = base. Here base means the value in force when the pulse was sampled.
- R5: `in_smm` rises together with `smi_entered` and falls one cycle after an accepted resume.
- R6: A resume pulse taken while `in_smm` is 1 with `resume_data[14:0]` = 0 loads `resume_data` into `base_out` one cycle later. The four published addresses keep their values until the next accepted entry, which uses the new base.
- R7: A resume pulse taken while `in_smm` is 1 with `resume_data[14:0]` nonzero sets `shutdown` one cycle later and leaves `base_out` and `in_smm` unchanged. `shutdown` then stays 1 until reset.
- R8: While `shutdown` is 1, entry and resume pulses have no effect: there is no `smi_entered` pulse, and `base_out` and `in_smm` do not change.
- R9: A resume pulse while `in_smm` is 0 has no effect on `base_out`, `in_smm` or `shutdown`. An entry pulse while `in_smm` is 1 gives no `smi_entered` pulse and leaves the published addresses unchanged.
- R10: `rev_id` has bit 17 set. With the default parameters it reads 0x0002_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| smi_req | input | 1 | One-cycle request to enter system-management mode |
| rsm_req | input | 1 | One-cycle request to resume, qualified by `resume_data` |
| resume_data | input | 32 | Word read back from the base slot of the save area |
| smi_entered | output | 1 | One-cycle pulse: entry accepted, addresses and slot data valid |
| handler_addr | output | 32 | Handler start address for the latest entry |
| save_top_addr | output | 32 | Highest save-area address, where saving begins |
| base_slot_addr | output | 32 | Save-area address that receives the base |
| base_slot_data | output | 32 | Base value to write into that slot |
| base_out | output | 32 | Current base register |
| in_smm | output | 1 | Core is inside system-management mode |
| shutdown | output | 1 | Sticky shutdown after a misaligned resume word |
| rev_id | output | 32 | Revision word, bit 17 marks relocation support |

## Verification
Each accepted request goes through exactly one register stage. The entry pulse, the four addresses, `in_smm`, the loaded base and `shutdown` all change at the first rising edge after the cycle in which the request is sampled. The bench raises each request on a falling edge and drops it on the next falling edge, so the request is sampled at exactly one rising edge. It reads every output on that second falling edge, half a period after the register stage updates. It also reads the outputs again one request later, which shows that a relocated base does not change the addresses already published and that ignored pulses leave all state as it was.

// File: rtl/smm_reloc_pkg.sv
package smm_reloc_pkg;

  localparam int unsigned WORD_W = 32;

  typedef logic [WORD_W-1:0] word_t;

  // handler start for a given base
  function automatic word_t fn_handler(input word_t base, input word_t entry_ofs);
    return base + entry_ofs;
  endfunction

  // highest save-area address (save grows downward from here)
  function automatic word_t fn_save_top(input word_t base, input word_t entry_ofs,
                                        input word_t span);
    return base + entry_ofs + span;
  endfunction

  // location of the base slot inside the save area
  function automatic word_t fn_slot(input word_t base, input word_t entry_ofs,
                                    input word_t slot_ofs);
    return base + entry_ofs + slot_ofs;
  endfunction

  // true when the low 'bits' bits of v are all zero
  function automatic logic fn_aligned(input word_t v, input int unsigned bits);
    word_t mask;
    mask = ~({WORD_W{1'b1}} << bits);
    return (v & mask) == '0;
  endfunction

endpackage

// File: rtl/smm_reloc_ctrl.sv
module smm_reloc_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic smi_req,
  input  logic rsm_req,
  input  logic word_ok,
  output logic smi_accept,
  output logic rsm_accept,
  output logic rsm_reject,
  output logic in_smm,
  output logic shutdown
);

  logic in_smm_q;
  logic shut_q;
  logic rsm_live;

  assign smi_accept = smi_req && !in_smm_q && !shut_q;
  assign rsm_live   = rsm_req && in_smm_q && !shut_q;
  assign rsm_accept = rsm_live && word_ok;
  assign rsm_reject = rsm_live && !word_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_smm_q <= 1'b0;
      shut_q   <= 1'b0;
    end else begin
      if (smi_accept) in_smm_q <= 1'b1;
      else if (rsm_accept) in_smm_q <= 1'b0;
      if (rsm_reject) shut_q <= 1'b1;
    end
  end

  assign in_smm   = in_smm_q;
  assign shutdown = shut_q;

endmodule

// File: rtl/smm_base_reg.sv
module smm_base_reg
  import smm_reloc_pkg::*;
#(
  parameter word_t       RESET_BASE = 32'h0003_0000,
  parameter int unsigned ALIGN_BITS = 15
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  word_t cand,
  output logic  cand_ok,
  output word_t base
);

  word_t base_q;

  assign cand_ok = fn_aligned(cand, ALIGN_BITS);

  always_ff @(posedge clk) begin
    if (!rst_n)    base_q <= RESET_BASE;
    else if (load) base_q <= cand;
  end

  assign base = base_q;

endmodule

// File: rtl/smm_addr_gen.sv
module smm_addr_gen
  import smm_reloc_pkg::*;
#(
  parameter word_t ENTRY_OFS = 32'h0000_8000,
  parameter word_t SAVE_SPAN = 32'h0000_7FFF,
  parameter word_t SLOT_OFS  = 32'h0000_7EF8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  fire,
  input  word_t base,
  output logic  pulse,
  output word_t handler,
  output word_t save_top,
  output word_t slot_addr,
  output word_t slot_data
);

  logic  pulse_q;
  word_t handler_q, top_q, slot_q, data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse_q   <= 1'b0;
      handler_q <= '0;
      top_q     <= '0;
      slot_q    <= '0;
      data_q    <= '0;
    end else begin
      pulse_q <= fire;
      if (fire) begin
        handler_q <= fn_handler(base, ENTRY_OFS);
        top_q     <= fn_save_top(base, ENTRY_OFS, SAVE_SPAN);
        slot_q    <= fn_slot(base, ENTRY_OFS, SLOT_OFS);
        data_q    <= base;
      end
    end
  end

  assign pulse     = pulse_q;
  assign handler   = handler_q;
  assign save_top  = top_q;
  assign slot_addr = slot_q;
  assign slot_data = data_q;

endmodule

// File: rtl/smm_reloc_unit.sv
module smm_reloc_unit
  import smm_reloc_pkg::*;
#(
  parameter logic [31:0] RESET_BASE = 32'h0003_0000,
  parameter logic [31:0] ENTRY_OFS  = 32'h0000_8000,
  parameter logic [31:0] SAVE_SPAN  = 32'h0000_7FFF,
  parameter logic [31:0] SLOT_OFS   = 32'h0000_7EF8,
  parameter int unsigned ALIGN_BITS = 15,
  parameter logic [31:0] REV_BASE   = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        smi_req,
  input  logic        rsm_req,
  input  logic [31:0] resume_data,
  output logic        smi_entered,
  output logic [31:0] handler_addr,
  output logic [31:0] save_top_addr,
  output logic [31:0] base_slot_addr,
  output logic [31:0] base_slot_data,
  output logic [31:0] base_out,
  output logic        in_smm,
  output logic        shutdown,
  output logic [31:0] rev_id
);

  localparam int unsigned RELOC_BIT = 17;
  localparam word_t REV_WORD = REV_BASE | (word_t'(1) << RELOC_BIT);

  // named internal events, observed by the bound checker
  logic  smi_accept;
  logic  rsm_accept;
  logic  rsm_reject;
  logic  word_ok;
  word_t base_q;

  smm_reloc_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .smi_req    (smi_req),
    .rsm_req    (rsm_req),
    .word_ok    (word_ok),
    .smi_accept (smi_accept),
    .rsm_accept (rsm_accept),
    .rsm_reject (rsm_reject),
    .in_smm     (in_smm),
    .shutdown   (shutdown)
  );

  smm_base_reg #(
    .RESET_BASE (RESET_BASE),
    .ALIGN_BITS (ALIGN_BITS)
  ) u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (rsm_accept),
    .cand    (resume_data),
    .cand_ok (word_ok),
    .base    (base_q)
  );

  smm_addr_gen #(
    .ENTRY_OFS (ENTRY_OFS),
    .SAVE_SPAN (SAVE_SPAN),
    .SLOT_OFS  (SLOT_OFS)
  ) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (smi_accept),
    .base      (base_q),
    .pulse     (smi_entered),
    .handler   (handler_addr),
    .save_top  (save_top_addr),
    .slot_addr (base_slot_addr),
    .slot_data (base_slot_data)
  );

  assign base_out = base_q;
  assign rev_id   = REV_WORD;

endmodule

// File: rtl/smm_reloc_chk.sv
module smm_reloc_chk #(
  parameter logic [31:0] ENTRY_OFS = 32'h0000_8000,
  parameter logic [31:0] SAVE_SPAN = 32'h0000_7FFF,
  parameter logic [31:0] SLOT_OFS  = 32'h0000_7EF8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        smi_req,
  input logic        rsm_req,
  input logic [31:0] resume_data,
  input logic        smi_entered,
  input logic [31:0] handler_addr,
  input logic [31:0] save_top_addr,
  input logic [31:0] base_slot_addr,
  input logic [31:0] base_slot_data,
  input logic [31:0] base_out,
  input logic        in_smm,
  input logic        shutdown,
  input logic        smi_accept,
  input logic        rsm_accept,
  input logic        rsm_reject
);

  assert_entry_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    smi_accept |=> smi_entered && in_smm && base_slot_data == $past(base_out));

  assert_handler_R2: assert property (@(posedge clk) disable iff (!rst_n)
    smi_entered |-> handler_addr == base_slot_data + ENTRY_OFS);

  assert_save_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    smi_entered |-> save_top_addr == base_slot_data + ENTRY_OFS + SAVE_SPAN);

  assert_slot_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    smi_entered |-> base_slot_addr == base_slot_data + ENTRY_OFS + SLOT_OFS);

  assert_reloc_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsm_accept |=> !in_smm && base_out == $past(resume_data) && $stable(handler_addr));

  assert_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsm_reject |=> shutdown && in_smm && $stable(base_out));

  assert_shut_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> shutdown);

  assert_shut_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> !smi_entered && $stable(base_out) && $stable(in_smm));

  assert_stray_resume_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsm_req && !smi_req && !in_smm) |=> !in_smm && $stable(base_out) && $stable(shutdown));

  assert_nested_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_req && in_smm) |=> !smi_entered && $stable(handler_addr));

endmodule

bind smm_reloc_unit smm_reloc_chk #(
  .ENTRY_OFS (ENTRY_OFS),
  .SAVE_SPAN (SAVE_SPAN),
  .SLOT_OFS  (SLOT_OFS)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .smi_req        (smi_req),
  .rsm_req        (rsm_req),
  .resume_data    (resume_data),
  .smi_entered    (smi_entered),
  .handler_addr   (handler_addr),
  .save_top_addr  (save_top_addr),
  .base_slot_addr (base_slot_addr),
  .base_slot_data (base_slot_data),
  .base_out       (base_out),
  .in_smm         (in_smm),
  .shutdown       (shutdown),
  .smi_accept     (smi_accept),
  .rsm_accept     (rsm_accept),
  .rsm_reject     (rsm_reject)
);

// File: tb/smm_reloc_unit_tb_top.sv
module smm_reloc_unit_tb_top;

  localparam logic [1:0] OP_SMI = 2'd1;
  localparam logic [1:0] OP_RSM = 2'd2;
  localparam int NSTEP = 12;

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] data;
  } step_t;

  localparam step_t STEPS [NSTEP] = '{
    '{OP_SMI, 32'h0000_0000},  // first entry from the reset base
    '{OP_RSM, 32'h0010_0000},  // aligned relocation
    '{OP_RSM, 32'h0020_0000},  // resume outside SMM: ignored
    '{OP_SMI, 32'h0000_0000},  // entry at the relocated base
    '{OP_SMI, 32'h0000_0000},  // nested entry: ignored
    '{OP_RSM, 32'hFFFF_8000},  // aligned, highest legal base
    '{OP_SMI, 32'h0000_0000},  // address sums wrap
    '{OP_RSM, 32'h0000_0000},  // base zero
    '{OP_SMI, 32'h0000_0000},
    '{OP_RSM, 32'h0004_0001},  // misaligned: shutdown
    '{OP_SMI, 32'h0000_0000},  // ignored in shutdown
    '{OP_RSM, 32'h0008_0000}   // ignored in shutdown
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smi_req = 1'b0;
  logic        rsm_req = 1'b0;
  logic [31:0] resume_data = '0;
  logic        smi_entered, in_smm, shutdown;
  logic [31:0] handler_addr, save_top_addr, base_slot_addr, base_slot_data;
  logic [31:0] base_out, rev_id;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  logic [31:0] m_base, m_hand, m_top, m_slot, m_sdata;
  logic        m_in, m_shut, m_pulse;

  always #2.5 clk = ~clk;

  smm_reloc_unit dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .smi_req        (smi_req),
    .rsm_req        (rsm_req),
    .resume_data    (resume_data),
    .smi_entered    (smi_entered),
    .handler_addr   (handler_addr),
    .save_top_addr  (save_top_addr),
    .base_slot_addr (base_slot_addr),
    .base_slot_data (base_slot_data),
    .base_out       (base_out),
    .in_smm         (in_smm),
    .shutdown       (shutdown),
    .rev_id         (rev_id)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_base = 32'h0003_0000;
    m_hand = '0; m_top = '0; m_slot = '0; m_sdata = '0;
    m_in = 1'b0; m_shut = 1'b0; m_pulse = 1'b0;
  endtask

  task automatic compare_all(input string ctx);
    chk({ctx, " R6 base_out"},       base_out,       m_base);
    chk({ctx, " R5 in_smm"},         {31'b0, in_smm},      {31'b0, m_in});
    chk({ctx, " R7 shutdown"},       {31'b0, shutdown},    {31'b0, m_shut});
    chk({ctx, " R2 smi_entered"},    {31'b0, smi_entered}, {31'b0, m_pulse});
    chk({ctx, " R2 handler_addr"},   handler_addr,   m_hand);
    chk({ctx, " R3 save_top_addr"},  save_top_addr,  m_top);
    chk({ctx, " R4 base_slot_addr"}, base_slot_addr, m_slot);
    chk({ctx, " R4 base_slot_data"}, base_slot_data, m_sdata);
  endtask

  // drive one request for one cycle, update the model, compare
  task automatic apply(input logic [1:0] op, input logic [31:0] data, input string ctx);
    @(negedge clk);
    smi_req     = (op == OP_SMI);
    rsm_req     = (op == OP_RSM);
    resume_data = data;
    m_pulse = 1'b0;
    if (op == OP_SMI && !m_in && !m_shut) begin
      m_hand  = m_base + 32'h0000_8000;
      m_top   = m_base + 32'h0000_FFFF;
      m_slot  = m_base + 32'h0000_FEF8;
      m_sdata = m_base;
      m_in    = 1'b1;
      m_pulse = 1'b1;
    end else if (op == OP_RSM && m_in && !m_shut) begin
      if (data[14:0] == 15'd0) begin
        m_base = data;
        m_in   = 1'b0;
      end else begin
        m_shut = 1'b1;
      end
    end
    @(negedge clk);
    smi_req = 1'b0;
    rsm_req = 1'b0;
    compare_all(ctx);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    smi_req = 1'b0; rsm_req = 1'b0; resume_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  initial begin
    model_reset();
    repeat (2) @(negedge clk);
    // R1: values while reset is held
    chk("R1 base during reset", base_out, 32'h0003_0000);
    chk("R1 shutdown during reset", {31'b0, shutdown}, 32'd0);
    do_reset();
    @(negedge clk);
    compare_all("R1 after reset");
    chk("R10 rev_id", rev_id, 32'h0002_0000);
    chk("R10 rev_id bit17", {31'b0, rev_id[17]}, 32'd1);

    for (int i = 0; i < NSTEP; i++) begin
      apply(STEPS[i].op, STEPS[i].data, $sformatf("step%0d", i));
    end
    // R8: shutdown persists with idle inputs
    repeat (3) @(negedge clk);
    chk("R7 shutdown sticky", {31'b0, shutdown}, 32'd1);

    // R1: reset clears shutdown and restores the default base
    do_reset();
    @(negedge clk);
    compare_all("R1 reset after shutdown");

    // R7: only bit 14 set is still misaligned
    apply(OP_SMI, 32'h0, "R2 entry default base");
    apply(OP_RSM, 32'h0000_4000, "R7 bit14 misaligned");
    // R9: a new entry while stuck in SMM is ignored
    apply(OP_SMI, 32'h0, "R8 entry after shutdown");

    // R6: relocated base applies to the next entry only
    do_reset();
    apply(OP_SMI, 32'h0, "R6 entry a");
    apply(OP_RSM, 32'h7FFF_8000, "R6 reload");
    chk("R6 handler held", handler_addr, 32'h0003_8000);
    apply(OP_SMI, 32'h0, "R6 entry b");
    chk("R6 new handler", handler_addr, 32'h8000_0000);
    chk("R4 new slot", base_slot_addr, 32'h8000_7EF8);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule